// File: doc/BRIEF.md
# Maskable Radio Interrupt Status Register

This block keeps three sticky event flags for a packet radio controller: receive data ready, transmit data sent and maximum retries reached. Each flag is raised by a one-cycle pulse from the datapath and is cleared by software writing a 1 to its bit of the status byte. A 3-bit mask held in the configuration register decides which flags may pull the active-low interrupt line.

The block also assembles the read-only part of the status byte. It shows the receive pipe number of the packet at the head of the receive FIFO, or all ones when that FIFO is empty, and a bit that reports a full transmit FIFO. While the maximum-retries flag is set, a hold output stops further transmission. The transmit-sent flag takes its set pulse from the end of transmission or, when auto-acknowledge is on, from the arrival of the acknowledgement.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset all three flags and all three mask bits are 0, irq_no is 1 and tx_block_o is 0.
- R2: A pulse on rx_evt_i sets status bit 6, and a pulse on max_retry_evt_i sets status bit 4. The flag is visible from the clock edge that samples the pulse.
- R3: A status write (stat_we_i) with 1 at bit 6, 5 or 4 of wdata_i clears that flag at the next edge. A 0 at that bit leaves the flag unchanged.
- R4: If a set pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: A config write (cfg_we_i) loads wdata_i[6:4] into the mask bits for the flags at status bits 6:4. A mask bit of 1 keeps its flag off irq_no. The flag itself still reads back in status_o.
- R6: irq_no is 0 exactly while at least one flag is set and its mask bit is 0.
- R7: Status bits 3:1 show rx_head_pipe_i while rx_fifo_empty_i is 0, and show 111 while it is 1.
- R8: Status bit 0 follows tx_fifo_full_i, and status bit 7 always reads 0.
- R9: With auto_ack_en_i at 1, a pulse on ack_rcvd_i sets status bit 5 and tx_done_i has no effect. With auto_ack_en_i at 0, a pulse on tx_done_i sets bit 5 and ack_rcvd_i has no effect.
- R10: tx_block_o is 1 exactly while the maximum-retries flag (status bit 4) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_evt_i | input | 1 | Receive data ready pulse |
| tx_done_i | input | 1 | Payload transmitted pulse |
| ack_rcvd_i | input | 1 | Acknowledgement received pulse |
| max_retry_evt_i | input | 1 | Retry limit reached pulse |
| auto_ack_en_i | input | 1 | Auto-acknowledge enabled for the current transmission |
| cfg_we_i | input | 1 | Configuration register write strobe |
| stat_we_i | input | 1 | Status register write strobe (write 1 to clear) |
| wdata_i | input | 8 | Register write data |
| rx_fifo_empty_i | input | 1 | Receive FIFO is empty |
| rx_head_pipe_i | input | 3 | Pipe number of the receive FIFO head entry |
| tx_fifo_full_i | input | 1 | Transmit FIFO is full |
| status_o | output | 8 | Status byte |
| mask_o | output | 3 | Mask bits for status bits 6:4 |
| irq_no | output | 1 | Active-low interrupt |
| tx_block_o | output | 1 | Transmission hold while retry limit is flagged |

## Verification
The flags are driven with single set pulses, status writes that mix 0 and 1 data bits, and a set that coincides with a clear. These cases separate true write-1-to-clear behaviour from plain overwrite, and show whether set or clear takes priority. The transmit-sent source is tried with end-of-transmission and acknowledgement pulses under both auto-acknowledge settings, so a swapped or ORed source selection shows up. Mask patterns are applied over set flags, which separates hiding a flag from the interrupt from clearing it. The pipe field is driven with a non-empty head and an empty FIFO to check the all-ones substitution.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_LSB  = 4;   // flags occupy status[6:4], masks cfg[6:4]
  localparam int unsigned PIPE_W    = 3;
  localparam int unsigned PIPE_LSB  = 1;
  localparam int unsigned FLAG_MSB  = FLAG_LSB + NUM_FLAGS - 1;
  localparam logic [PIPE_W-1:0] PIPE_EMPTY = '1;

  // flag index: 0 = retry limit (bit 4), 1 = tx sent (bit 5), 2 = rx ready (bit 6)
  typedef enum logic [1:0] {
    FLG_MAX_RT = 2'd0,
    FLG_TX_DS  = 2'd1,
    FLG_RX_DR  = 2'd2
  } flag_idx_e;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set has priority over clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/irq_tx_src_sel.sv
module irq_tx_src_sel (
  input  logic auto_ack_en_i,
  input  logic tx_done_i,
  input  logic ack_rcvd_i,
  output logic tx_set_o
);
  always_comb begin
    if (auto_ack_en_i) tx_set_o = ack_rcvd_i;
    else               tx_set_o = tx_done_i;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_evt_i,
  input  logic              tx_done_i,
  input  logic              ack_rcvd_i,
  input  logic              max_retry_evt_i,
  input  logic              auto_ack_en_i,
  input  logic              cfg_we_i,
  input  logic              stat_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rx_fifo_empty_i,
  input  logic [PIPE_W-1:0] rx_head_pipe_i,
  input  logic              tx_fifo_full_i,
  output logic [DATA_W-1:0] status_o,
  output logic [NUM_FLAGS-1:0] mask_o,
  output logic              irq_no,
  output logic              tx_block_o
);
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] flags;
  logic                 tx_set;
  logic [PIPE_W-1:0]    pipe_field;

  irq_tx_src_sel u_tx_sel (
    .auto_ack_en_i (auto_ack_en_i),
    .tx_done_i     (tx_done_i),
    .ack_rcvd_i    (ack_rcvd_i),
    .tx_set_o      (tx_set)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLG_MAX_RT] = max_retry_evt_i;
    set_vec[FLG_TX_DS]  = tx_set;
    set_vec[FLG_RX_DR]  = rx_evt_i;
  end

  assign clr_vec = {NUM_FLAGS{stat_we_i}} & wdata_i[FLAG_MSB:FLAG_LSB];

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    irq_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .flag_o (flags[g])
    );
  end

  irq_mask_reg #(.WIDTH(NUM_FLAGS)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .d_i    (wdata_i[FLAG_MSB:FLAG_LSB]),
    .q_o    (mask_o)
  );

  assign pipe_field = rx_fifo_empty_i ? PIPE_EMPTY : rx_head_pipe_i;

  always_comb begin
    status_o                        = '0;
    status_o[FLAG_MSB:FLAG_LSB]     = flags;
    status_o[PIPE_LSB+PIPE_W-1:PIPE_LSB] = pipe_field;
    status_o[0]                     = tx_fifo_full_i;
  end

  assign irq_no     = ~|(flags & ~mask_o);
  assign tx_block_o = flags[FLG_MAX_RT];
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_evt_i,
  input logic       tx_done_i,
  input logic       ack_rcvd_i,
  input logic       max_retry_evt_i,
  input logic       auto_ack_en_i,
  input logic       cfg_we_i,
  input logic       stat_we_i,
  input logic [7:0] wdata_i,
  input logic       rx_fifo_empty_i,
  input logic [7:0] status_o,
  input logic [2:0] mask_o,
  input logic       irq_no,
  input logic       tx_block_o
);
  p_rx_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_i |=> status_o[6]);
  p_mr_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    max_retry_evt_i |=> status_o[4]);
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && wdata_i[6] && !rx_evt_i) |=> !status_o[6]);
  p_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && !wdata_i[4] && !max_retry_evt_i) |=> status_o[4] == $past(status_o[4]));
  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && wdata_i[4] && max_retry_evt_i) |=> status_o[4]);
  p_mask_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> mask_o == $past(wdata_i[6:4]));
  p_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == !(|(status_o[6:4] & ~mask_o)));
  p_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fifo_empty_i |-> status_o[3:1] == 3'b111);
  p_msb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[7]);
  p_txsrc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((auto_ack_en_i && ack_rcvd_i) || (!auto_ack_en_i && tx_done_i)) |=> status_o[5]);
  p_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_block_o == status_o[4]);
endmodule

bind irq_status_ctrl irq_status_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rx_evt_i        (rx_evt_i),
  .tx_done_i       (tx_done_i),
  .ack_rcvd_i      (ack_rcvd_i),
  .max_retry_evt_i (max_retry_evt_i),
  .auto_ack_en_i   (auto_ack_en_i),
  .cfg_we_i        (cfg_we_i),
  .stat_we_i       (stat_we_i),
  .wdata_i         (wdata_i),
  .rx_fifo_empty_i (rx_fifo_empty_i),
  .status_o        (status_o),
  .mask_o          (mask_o),
  .irq_no          (irq_no),
  .tx_block_o      (tx_block_o)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_evt = 0, tx_done = 0, ack = 0, mr_evt = 0, aa_en = 0;
  logic       cfg_we = 0, stat_we = 0;
  logic [7:0] wdata = '0;
  logic       rx_empty = 1'b1;
  logic [2:0] head = '0;
  logic       tx_full = 1'b0;
  logic [7:0] status;
  logic [2:0] mask;
  logic       irq_n, blk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] st;
    logic [2:0] mk;
    logic       irq_n;
    logic       blk;
    string      tag;
  } exp_t;
  exp_t q[$];

  // bench model of flags [2]=rx ready, [1]=tx sent, [0]=retry limit
  logic [2:0] m_flags = '0;
  logic [2:0] m_mask  = '0;

  always #2 clk = ~clk;

  irq_status_ctrl dut (
    .clk_i (clk), .rst_ni (rst_n),
    .rx_evt_i (rx_evt), .tx_done_i (tx_done), .ack_rcvd_i (ack),
    .max_retry_evt_i (mr_evt), .auto_ack_en_i (aa_en),
    .cfg_we_i (cfg_we), .stat_we_i (stat_we), .wdata_i (wdata),
    .rx_fifo_empty_i (rx_empty), .rx_head_pipe_i (head), .tx_fifo_full_i (tx_full),
    .status_o (status), .mask_o (mask), .irq_no (irq_n), .tx_block_o (blk)
  );

  function automatic void cmp(string tag, logic [7:0] st, logic [2:0] mk, logic i, logic b);
    checks++;
    if (status !== st || mask !== mk || irq_n !== i || blk !== b) begin
      errors++;
      $display("FAIL %s: status=%h mask=%b irq_n=%b blk=%b expected status=%h mask=%b irq_n=%b blk=%b",
               tag, status, mask, irq_n, blk, st, mk, i, b);
    end
  endfunction

  // driver: apply one cycle of stimulus at negedge and push the expected result
  task automatic step(input logic rx, input logic td, input logic ak, input logic mr,
                      input logic aa, input logic cw, input logic sw, input logic [7:0] wd,
                      input logic emp, input logic [2:0] hp, input logic tf, input string tag);
    logic [2:0] set_v, clr_v;
    exp_t e;
    @(negedge clk);
    rx_evt = rx; tx_done = td; ack = ak; mr_evt = mr; aa_en = aa;
    cfg_we = cw; stat_we = sw; wdata = wd; rx_empty = emp; head = hp; tx_full = tf;
    set_v = {rx, aa ? ak : td, mr};
    clr_v = sw ? wd[6:4] : 3'b000;
    m_flags = set_v | (m_flags & ~clr_v);
    if (cw) m_mask = wd[6:4];
    e.st    = {1'b0, m_flags, emp ? 3'b111 : hp, tf};
    e.mk    = m_mask;
    e.irq_n = ~|(m_flags & ~m_mask);
    e.blk   = m_flags[0];
    e.tag   = tag;
    q.push_back(e);
  endtask

  // monitor: compare just after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, e.st, e.mk, e.irq_n, e.blk);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #9;
    cmp("R1 reset", 8'h0E, 3'b000, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    //    rx td ak mr aa cw sw wd     emp hp    tf
    step(0, 0, 0, 0, 0, 0, 0, 8'h00, 1, 3'd0, 0, "R1 idle after reset");
    step(1, 0, 0, 0, 0, 0, 0, 8'h00, 1, 3'd0, 0, "R2 rx ready sets bit6");
    step(0, 0, 0, 0, 0, 0, 1, 8'h8F, 1, 3'd0, 0, "R3 write 0 at flag keeps it");
    step(0, 0, 0, 0, 0, 0, 1, 8'h40, 1, 3'd0, 0, "R3 write 1 clears bit6");
    step(0, 1, 0, 0, 0, 0, 0, 8'h00, 1, 3'd0, 0, "R9 tx_done sets bit5 without auto-ack");
    step(0, 0, 1, 0, 0, 0, 1, 8'h20, 1, 3'd0, 0, "R9 ack ignored without auto-ack, R3 clear");
    step(0, 1, 0, 0, 1, 0, 0, 8'h00, 1, 3'd0, 0, "R9 tx_done ignored with auto-ack");
    step(0, 0, 1, 0, 1, 0, 0, 8'h00, 1, 3'd0, 0, "R9 ack sets bit5 with auto-ack");
    step(0, 0, 0, 1, 0, 0, 1, 8'h10, 1, 3'd0, 0, "R4 set wins over clear, R10 block");
    step(0, 0, 0, 0, 0, 0, 0, 8'h00, 1, 3'd0, 0, "R10 block holds");
    step(0, 0, 0, 0, 0, 1, 0, 8'h70, 1, 3'd0, 0, "R5 mask all, R6 irq released");
    step(1, 0, 0, 0, 0, 1, 0, 8'h30, 1, 3'd0, 0, "R5 unmask rx only, R6 irq");
    step(0, 0, 0, 0, 0, 1, 0, 8'h40, 1, 3'd0, 0, "R6 rx masked, others unmasked");
    step(0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 3'd3, 1, "R7 head pipe 3, R8 tx full");
    step(0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 3'd5, 0, "R7 head pipe 5");
    step(0, 0, 0, 0, 0, 0, 0, 8'h00, 1, 3'd5, 1, "R7 empty reads 111, R8");
    step(0, 0, 0, 0, 0, 0, 1, 8'h70, 1, 3'd0, 0, "R3 clear all, R10 block drops");
    step(0, 0, 0, 0, 0, 1, 0, 8'h00, 1, 3'd0, 0, "R5 unmask with flags clear");
    step(0, 0, 0, 0, 0, 0, 0, 8'h00, 1, 3'd0, 0, "R6 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule